// File: doc/BRIEF.md
# BCD Calendar Timekeeping Core

This block keeps wall-clock time in packed BCD: seconds, minutes, hours, day of month, weekday, month with a century bit, and a two-digit year. A qualifying enable `tick_i` arrives at 32.768 kHz. An internal prescaler counts these enables and produces one time step per second. The rollover logic handles 60-second minutes, 60-minute hours and 24-hour days. It also handles month lengths that depend on the month, and a 29-day February in years that are multiples of four, which is correct for the years 2000 to 2099.

Software reaches a 16-byte register file through a synchronous access port. The port has no handshake. In a cycle with `req_i` high, the beat goes to `addr_i` when `first_i` is high. Otherwise it goes to an internal pointer, which moves to the next address after every beat. This lets a seven-beat burst that starts at the seconds byte cover the whole time. Read data is combinational for the beat in progress.

A stop bit halts counting so that a new time can be written as one consistent set. A sticky flag in the top bit of the seconds byte marks the time as not trustworthy until software writes it.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the registers read as follows:
  - seconds 0x80: time 00:00:00 with the invalid flag set
  - minutes 0x00 and hours 0x00
  - day 0x01
  - weekday 0x06
  - month 0x01, with the century bit clear
  - year 0x00
  - stop bit clear
- R2: While running, the time advances by exactly one second on the `tick_i` cycle that completes `TICKS_PER_SEC` counted enables. Cycles without `tick_i` neither count nor step.
- R3: Seconds and minutes roll over from 0x59 to 0x00 and carry into the next field. Hours roll over from 0x23 to 0x00 and carry into both the day and the weekday.
- R4: The weekday uses the codes 0 to 6, where 0 is Sunday. It advances at every midnight and wraps from 6 to 0, independently of the day of month.
- R5: Day limits are as follows:
  - 0x30 for months 0x04, 0x06, 0x09 and 0x11
  - 0x29 for month 0x02 when the year is a multiple of four, and 0x28 in other years
  - 0x31 for every other month

  Past the limit the day returns to 0x01. Month 0x12 returns to 0x01 and carries into the year.
- R6: The year wraps from 0x99 to 0x00, and that wrap inverts the century bit (month byte, bit 7).
- R7: Bit 7 of the seconds byte is the invalid flag. It is set at reset and is loaded from bit 7 of every write to the seconds byte. Counting never changes it.
- R8: The stop bit is bit 5 of the control byte at address 0x00. While it is set, no step occurs and the prescaler is held at zero, so the first step after release comes a full `TICKS_PER_SEC` enables later.
- R9: The map is control at 0x00, then seconds, minutes, hours, day, weekday, month and year at 0x02 to 0x08. Only the following bits are stored, and all other bits read as 0:
  - 7 bits of seconds and minutes
  - 6 bits of hours and day
  - 3 bits of weekday
  - 5 bits of month
  - 8 bits of year

  Addresses 0x01 and 0x09 to 0x0F read 0 and ignore writes.
- R10: The effective address is `addr_i` when `first_i` is high and the pointer otherwise. After each beat the pointer becomes the effective address plus one, wrapping from 0x0F to 0x00.
- R11: When a write to a time byte falls in the same cycle as a step, the written byte takes the written value and every other byte takes its stepped value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle enable at the 32.768 kHz rate |
| req_i | input | 1 | Access beat valid |
| we_i | input | 1 | Beat is a write |
| first_i | input | 1 | Beat uses `addr_i` instead of the internal pointer |
| addr_i | input | 4 | Byte address for a first beat |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the effective address of this cycle |

## Verification
The colliding case is a software write to a time byte in the same cycle as the second step. A step that carries, such as seconds wrapping from 59, makes that collision more serious. The bench provokes it by writing the minutes byte on every cycle across a seconds rollover, with the prescaler phase free-running. A behavioural model applies the step first and then overlays the written byte. It compares every register read on every clock, so a design that drops either the write or the carry into its neighbours shows a mismatch within one cycle.

// File: rtl/bcd_rtc_pkg.sv
`timescale 1ns/1ps
package bcd_rtc_pkg;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_CTRL = 4'h0;
  localparam logic [ADDR_W-1:0] A_SEC  = 4'h2;
  localparam logic [ADDR_W-1:0] A_MIN  = 4'h3;
  localparam logic [ADDR_W-1:0] A_HOUR = 4'h4;
  localparam logic [ADDR_W-1:0] A_DAY  = 4'h5;
  localparam logic [ADDR_W-1:0] A_WDAY = 4'h6;
  localparam logic [ADDR_W-1:0] A_MON  = 4'h7;
  localparam logic [ADDR_W-1:0] A_YEAR = 4'h8;

  localparam int STOP_BIT = 5;

  typedef struct packed {
    logic [6:0] sec;
    logic [6:0] min;
    logic [5:0] hour;
    logic [5:0] day;
    logic [2:0] wday;
    logic [4:0] mon;
    logic [7:0] year;
    logic       cent;
  } cal_t;

  localparam cal_t CAL_RESET = '{sec: 7'h00, min: 7'h00, hour: 6'h00, day: 6'h01,
                                 wday: 3'd6, mon: 5'h01, year: 8'h00, cent: 1'b0};

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : v + 8'd1;
  endfunction

  // value at or past its limit returns to lo, else BCD increment
  function automatic logic [7:0] bcd_step(input logic [7:0] v, input logic [7:0] lim,
                                          input logic [7:0] lo);
    return (v >= lim) ? lo : bcd_inc(v);
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
`timescale 1ns/1ps
module rtc_prescaler #(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic hold_i,
  output logic step_o
);
  localparam int CW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (hold_i)  cnt_q <= '0;
    else if (tick_i)  cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign step_o = tick_i && !hold_i && (cnt_q == LAST);
endmodule

// File: rtl/rtc_calendar_next.sv
`timescale 1ns/1ps
module rtc_calendar_next
  import bcd_rtc_pkg::*;
(
  input  cal_t cur_i,
  output cal_t nxt_o
);
  logic [7:0] sec8, min8, hr8, day8, mon8;
  logic [7:0] sec_n, min_n, hr_n, day_n, mon_n, yr_n;
  logic [7:0] dim;
  logic       leap;
  logic       w_sec, w_min, w_hr, w_day, w_mon, w_yr;
  logic       c_hr, c_day, c_mon, c_yr, c_cent;

  assign sec8 = {1'b0, cur_i.sec};
  assign min8 = {1'b0, cur_i.min};
  assign hr8  = {2'b0, cur_i.hour};
  assign day8 = {2'b0, cur_i.day};
  assign mon8 = {3'b0, cur_i.mon};

  // odd tens digit: multiple of 4 iff units is 2 or 6
  assign leap = cur_i.year[4] ? (cur_i.year[1:0] == 2'b10) : (cur_i.year[1:0] == 2'b00);

  always_comb begin
    unique case (cur_i.mon)
      5'h02:                      dim = leap ? 8'h29 : 8'h28;
      5'h04, 5'h06, 5'h09, 5'h11: dim = 8'h30;
      default:                    dim = 8'h31;
    endcase
  end

  assign w_sec = sec8 >= 8'h59;
  assign w_min = min8 >= 8'h59;
  assign w_hr  = hr8  >= 8'h23;
  assign w_day = day8 >= dim;
  assign w_mon = mon8 >= 8'h12;
  assign w_yr  = cur_i.year >= 8'h99;

  assign sec_n = bcd_step(sec8, 8'h59, 8'h00);
  assign min_n = bcd_step(min8, 8'h59, 8'h00);
  assign hr_n  = bcd_step(hr8, 8'h23, 8'h00);
  assign day_n = bcd_step(day8, dim, 8'h01);
  assign mon_n = bcd_step(mon8, 8'h12, 8'h01);
  assign yr_n  = bcd_step(cur_i.year, 8'h99, 8'h00);

  assign c_hr   = w_sec && w_min;
  assign c_day  = c_hr && w_hr;
  assign c_mon  = c_day && w_day;
  assign c_yr   = c_mon && w_mon;
  assign c_cent = c_yr && w_yr;

  always_comb begin
    nxt_o = cur_i;
    nxt_o.sec = sec_n[6:0];
    if (w_sec) nxt_o.min = min_n[6:0];
    if (c_hr)  nxt_o.hour = hr_n[5:0];
    if (c_day) begin
      nxt_o.day  = day_n[5:0];
      nxt_o.wday = (cur_i.wday >= 3'd6) ? 3'd0 : cur_i.wday + 3'd1;
    end
    if (c_mon)  nxt_o.mon  = mon_n[4:0];
    if (c_yr)   nxt_o.year = yr_n;
    if (c_cent) nxt_o.cent = ~cur_i.cent;
  end
endmodule

// File: rtl/bcd_rtc_core.sv
`timescale 1ns/1ps
module bcd_rtc_core
  import bcd_rtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              first_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o
);
  cal_t              tm_q, tm_d, tm_nxt;
  logic              vl_q, vl_d, stop_q, stop_d, step;
  logic [ADDR_W-1:0] ptr_q, eff_addr;
  logic              wr;

  assign eff_addr = first_i ? addr_i : ptr_q;
  assign wr       = req_i && we_i;

  rtc_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .hold_i (stop_q),
    .step_o (step)
  );

  rtc_calendar_next u_next (
    .cur_i (tm_q),
    .nxt_o (tm_nxt)
  );

  // write overlays the stepped value byte by byte
  always_comb begin
    tm_d   = step ? tm_nxt : tm_q;
    vl_d   = vl_q;
    stop_d = stop_q;
    if (wr) begin
      unique case (eff_addr)
        A_CTRL: stop_d = wdata_i[STOP_BIT];
        A_SEC:  begin tm_d.sec = wdata_i[6:0]; vl_d = wdata_i[7]; end
        A_MIN:  tm_d.min  = wdata_i[6:0];
        A_HOUR: tm_d.hour = wdata_i[5:0];
        A_DAY:  tm_d.day  = wdata_i[5:0];
        A_WDAY: tm_d.wday = wdata_i[2:0];
        A_MON:  begin tm_d.mon = wdata_i[4:0]; tm_d.cent = wdata_i[7]; end
        A_YEAR: tm_d.year = wdata_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tm_q   <= CAL_RESET;
      vl_q   <= 1'b1;
      stop_q <= 1'b0;
      ptr_q  <= '0;
    end else begin
      tm_q   <= tm_d;
      vl_q   <= vl_d;
      stop_q <= stop_d;
      if (req_i) ptr_q <= eff_addr + 1'b1;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (eff_addr)
      A_CTRL: rdata_o[STOP_BIT] = stop_q;
      A_SEC:  rdata_o = {vl_q, tm_q.sec};
      A_MIN:  rdata_o = {1'b0, tm_q.min};
      A_HOUR: rdata_o = {2'b0, tm_q.hour};
      A_DAY:  rdata_o = {2'b0, tm_q.day};
      A_WDAY: rdata_o = {5'b0, tm_q.wday};
      A_MON:  rdata_o = {tm_q.cent, 2'b0, tm_q.mon};
      A_YEAR: rdata_o = tm_q.year;
      default: ;
    endcase
  end
endmodule

// File: rtl/bcd_rtc_core_chk.sv
`timescale 1ns/1ps
module bcd_rtc_core_chk
  import bcd_rtc_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] eff_addr_i,
  input logic [ADDR_W-1:0] ptr_i,
  input logic              vl_i,
  input logic              stop_i,
  input logic              step_i,
  input logic [6:0]        sec_i,
  input logic [6:0]        min_i
);
  logic wr;
  assign wr = req_i && we_i;

  p_flag_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vl_i && !(wr && eff_addr_i == A_SEC) |=> vl_i);

  p_no_step_stopped_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |-> !step_i);

  p_frozen_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i && !wr |=> $stable(sec_i) && $stable(min_i));

  p_sec_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i && !wr |=> $stable(sec_i));

  p_min_carry_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && sec_i == 7'h59 && !wr |=> sec_i == 7'h00 && min_i != $past(min_i));

  p_ptr_wrap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && eff_addr_i == 4'hF |=> ptr_i == 4'h0);
endmodule

bind bcd_rtc_core bcd_rtc_core_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .we_i       (we_i),
  .eff_addr_i (eff_addr),
  .ptr_i      (ptr_q),
  .vl_i       (vl_q),
  .stop_i     (stop_q),
  .step_i     (step),
  .sec_i      (tm_q.sec),
  .min_i      (tm_q.min)
);

// File: tb/test_bcd_rtc_core.sv
`timescale 1ns/1ps
module test_bcd_rtc_core;
  localparam int TPS = 4;

  logic       clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic       req = 1'b0, we = 1'b0, first = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  wire  [7:0] rdata;

  always #2 clk = ~clk;

  bcd_rtc_core #(.TICKS_PER_SEC(TPS)) i_bcd_rtc_core (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .req_i(req), .we_i(we),
    .first_i(first), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata)
  );

  int total = 0, bad = 0, ncyc = 0, tick_mode = 2;
  string tag = "R1";
  bit done = 0;

  // reference state, bytes as read back
  int m_sec = 0, m_min = 0, m_hour = 0, m_day = 1, m_wday = 6, m_mon = 1, m_year = 0;
  int m_cent = 0, m_vl = 1, m_stop = 0, m_presc = 0, m_ptr = 0;

  function automatic int b2i(int b); return (b >> 4) * 10 + (b & 15); endfunction
  function automatic int i2b(int v); return ((v / 10) << 4) | (v % 10); endfunction

  function automatic int exp_read(int a);
    case (a)
      0: return m_stop << 5;
      2: return (m_vl << 7) | m_sec;
      3: return m_min;
      4: return m_hour;
      5: return m_day;
      6: return m_wday;
      7: return (m_cent << 7) | m_mon;
      8: return m_year;
      default: return 0;
    endcase
  endfunction

  task automatic advance();
    int s = b2i(m_sec), mi = b2i(m_min), h = b2i(m_hour), d = b2i(m_day);
    int mo = b2i(m_mon), y = b2i(m_year), w = m_wday, lim;
    if (mo == 2) lim = (y % 4 == 0) ? 29 : 28;
    else if (mo == 4 || mo == 6 || mo == 9 || mo == 11) lim = 30;
    else lim = 31;
    if (s >= 59) begin
      s = 0;
      if (mi >= 59) begin
        mi = 0;
        if (h >= 23) begin
          h = 0;
          w = (w >= 6) ? 0 : w + 1;
          if (d >= lim) begin
            d = 1;
            if (mo >= 12) begin
              mo = 1;
              if (y >= 99) begin y = 0; m_cent = 1 - m_cent; end
              else y = y + 1;
            end else mo = mo + 1;
          end else d = d + 1;
        end else h = h + 1;
      end else mi = mi + 1;
    end else s = s + 1;
    m_sec = i2b(s); m_min = i2b(mi); m_hour = i2b(h); m_day = i2b(d);
    m_wday = w; m_mon = i2b(mo); m_year = i2b(y);
  endtask

  task automatic model_update(bit t, bit r, bit w, int ea, int d);
    bit stp;
    stp = t && (m_presc == TPS - 1) && !m_stop;
    if (m_stop) m_presc = 0;
    else if (t) m_presc = (m_presc == TPS - 1) ? 0 : m_presc + 1;
    if (stp) advance();
    if (r && w) begin
      case (ea)
        0: m_stop = (d >> 5) & 1;
        2: begin m_vl = (d >> 7) & 1; m_sec = d & 8'h7f; end
        3: m_min = d & 8'h7f;
        4: m_hour = d & 8'h3f;
        5: m_day = d & 8'h3f;
        6: m_wday = d & 7;
        7: begin m_mon = d & 8'h1f; m_cent = (d >> 7) & 1; end
        8: m_year = d & 8'hff;
        default: ;
      endcase
    end
    if (r) m_ptr = (ea + 1) % 16;
  endtask

  task automatic cyc(bit r, bit w, bit f, int a, int d);
    bit t;
    int ea, ex;
    t = (tick_mode == 0) ? 1'b1 : (tick_mode == 1) ? (ncyc % 3 == 0) : 1'b0;
    tick = t; req = r; we = w; first = f; addr = a[3:0]; wdata = d[7:0];
    ea = f ? a : m_ptr;
    #1;
    ex = exp_read(ea);
    total++;
    if (rdata !== ex[7:0]) begin
      bad++;
      $display("FAIL %s addr=%0h got=%02h exp=%02h", tag, ea, rdata, ex[7:0]);
    end
    @(posedge clk);
    model_update(t, r, w, ea, d);
    ncyc++;
    @(negedge clk);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cyc(1, 0, i == 0, 0, 0);
  endtask

  task automatic wr(int a, int d); cyc(1, 1, 1, a, d); endtask

  task automatic set_time(int s, int mi, int h, int d, int w, int mo, int y);
    wr(0, 8'h20);
    cyc(1, 1, 1, 2, s);
    cyc(1, 1, 0, 0, mi);
    cyc(1, 1, 0, 0, h);
    cyc(1, 1, 0, 0, d);
    cyc(1, 1, 0, 0, w);
    cyc(1, 1, 0, 0, mo);
    cyc(1, 1, 0, 0, y);
    wr(0, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tag = "R1"; run(16);
    tag = "R10"; for (int i = 0; i < 6; i++) cyc(1, 0, i == 0, 14, 0);
    tag = "R7"; wr(2, 8'h05); run(4); wr(2, 8'h85); run(4); wr(2, 8'h10); run(4);
    tag = "R2"; tick_mode = 0; run(40); tick_mode = 1; run(60); tick_mode = 0;
    tag = "R3"; set_time(8'h57, 8'h59, 8'h23, 8'h15, 3, 8'h06, 8'h21); run(24);
    tag = "R4"; set_time(8'h58, 8'h59, 8'h23, 8'h10, 6, 8'h07, 8'h22); run(16);
    tag = "R5";
    set_time(8'h59, 8'h59, 8'h23, 8'h28, 1, 8'h02, 8'h24); run(12);
    set_time(8'h59, 8'h59, 8'h23, 8'h29, 2, 8'h02, 8'h24); run(12);
    set_time(8'h59, 8'h59, 8'h23, 8'h28, 2, 8'h02, 8'h23); run(12);
    set_time(8'h59, 8'h59, 8'h23, 8'h30, 0, 8'h04, 8'h23); run(12);
    set_time(8'h59, 8'h59, 8'h23, 8'h30, 0, 8'h05, 8'h23); run(12);
    set_time(8'h59, 8'h59, 8'h23, 8'h31, 5, 8'h12, 8'h23); run(12);
    tag = "R6";
    set_time(8'h58, 8'h59, 8'h23, 8'h31, 4, 8'h12, 8'h99); run(16);
    set_time(8'h58, 8'h59, 8'h23, 8'h31, 4, 8'h92, 8'h99); run(16);
    tag = "R8"; run(6); wr(0, 8'h20); run(30); wr(0, 8'h00); run(24);
    tag = "R9";
    wr(0, 8'h20);
    for (int a = 0; a < 16; a++) wr(a, 8'hFF);
    run(20);
    set_time(8'h30, 8'h45, 8'h12, 8'h09, 2, 8'h03, 8'h25); run(8);
    tag = "R11";
    set_time(8'h57, 8'h00, 8'h10, 8'h09, 2, 8'h03, 8'h25);
    for (int i = 0; i < 16; i++) cyc(1, 1, 1, 3, i2b(20 + i));
    run(20);
    for (int i = 0; i < 12; i++) cyc(1, 1, 1, 2, i2b(50 + i));
    run(20);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog got=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule